// File: doc/BRIEF.md
# Four-Channel Prioritized DMA Controller

The block holds four independent DMA channels, each programmed through a small write port with a source address, a destination address, a unit count and a control word. Once enabled, a channel moves its block one unit at a time, either 16 or 32 bits wide. Each unit is a read followed by a write on a single memory master port with a valid/ready handshake. A block starts in one of four ways, chosen per channel: at once when the channel is enabled, on a horizontal-blank pulse, on a vertical-blank pulse, or on a FIFO request. The FIFO request exists for channels 1 and 2 only.

The channels share the master port. At every unit boundary, a fixed-priority arbiter hands the port to the lowest-numbered pending channel. A channel either ends its block by clearing its own enable bit, or, in repeat mode, reloads and waits for its next trigger. Repeat mode can also restore the original destination. A one-cycle interrupt pulse can mark the end of each block. Software reads back the stored control words through a read-select port.

Top module: `dma4_ctrl`

## Requirements
- R1: Register select codes are 0 source, 1 destination, 2 count, 3 control. A write to the source or destination address stores it with bit 0 forced to zero. For 32-bit units, the master port also presents addresses with bits 1:0 cleared.
- R2: A write of 0 to the count register loads the maximum: 2^CNT_W units for channel 3 and 2^(CNT_W-2) units for channels 0 to 2. Any other value loads as written.
- R3: Control bits [8:7] step the source address and bits [6:5] step the destination address after each unit. Code 0 adds one unit size, code 1 subtracts one, code 2 holds the address and code 3 adds one. Bit 10 selects 32-bit units (size 4) over 16-bit units (size 2).
- R4: In repeat mode, destination code 3 restores the programmed destination at the end of each block. Code 0 carries on from where the block stopped. The source always carries on.
- R5: The working source, destination and count are loaded from the programmed registers only when the enable bit (bit 15) goes from 0 to 1. Address writes made while a channel is enabled do not affect its current transfer.
- R6: Control bits [13:12] select the trigger: 0 starts the block on enable, 1 starts it on a vblank pulse, 2 on an hblank pulse, and 3 on a FIFO request. FIFO request bit 0 serves channel 1 and bit 1 serves channel 2. Channels 0 and 3 never start with code 3.
- R7: When several channels are pending, the lowest-numbered one gets the port. A higher-priority channel takes over only after the current unit's write completes.
- R8: When a block ends with repeat (bit 9) clear, the stored control word becomes its previous value ANDed with 0x7FE0. This clears the enable bit.
- R9: When a block ends with repeat set, the count reloads, the enable bit stays set, and no further access is made until the channel's next trigger.
- R10: If control bit 14 is set, the channel's irq bit pulses for exactly one cycle, in the cycle after the final write handshake of each block.
- R11: Each unit is one read followed by one write to the destination. m_valid and the address stay stable until m_ready. m_seq is 0 for both accesses of a block's first unit and 1 for later units.
- R12: A control write with enable set may land in the same cycle as the final write handshake of a non-repeating block on that channel. Such a write counts as a new enable: it relatches the working registers and runs a fresh block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_reg | input | 2 | Register select (0 src, 1 dst, 2 count, 3 control) |
| cfg_wdata | input | 32 | Write data |
| ctrl_rd_sel | input | 2 | Channel whose control word is shown |
| ctrl_rd_data | output | 16 | Stored control word of the selected channel |
| vblank | input | 1 | Vertical-blank trigger pulse |
| hblank | input | 1 | Horizontal-blank trigger pulse |
| fifo_req | input | 2 | FIFO requests for channels 1 and 2 |
| irq | output | 4 | Per-channel end-of-block pulses |
| m_valid | output | 1 | Master request valid |
| m_write | output | 1 | 1 write, 0 read |
| m_wide | output | 1 | 1 for 32-bit access, 0 for 16-bit |
| m_seq | output | 1 | 0 on a block's first unit, 1 on later units |
| m_addr | output | 32 | Master address |
| m_wdata | output | 32 | Master write data |
| m_ready | input | 1 | Memory accepts/completes the access |
| m_rdata | input | 32 | Read data, valid with m_ready on a read |

## Verification
A control-register write from software and the engine's own end-of-block update can hit the same channel in the same cycle, and they disagree about the enable bit. The bench provokes this by watching for the write phase of a one-unit block and issuing a control write with enable set so that it lands on that unit's handshake edge. It judges the outcome at the ports: exactly two write handshakes follow, both reads come from the relatched source, and the control word ends disabled once the second block is done.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int BIT_EN   = 15;
  localparam int BIT_IRQ  = 14;
  localparam int BIT_W32  = 10;
  localparam int BIT_RPT  = 9;
  localparam logic [15:0] END_MASK = 16'h7FE0;

  typedef enum logic [1:0] {TM_NOW = 2'd0, TM_VBL = 2'd1, TM_HBL = 2'd2, TM_FIFO = 2'd3} trig_e;
  typedef enum logic [1:0] {E_IDLE = 2'd0, E_RD = 2'd1, E_WR = 2'd2} eng_e;

  function automatic logic [31:0] step_addr(input logic [31:0] a, input logic [1:0] code,
                                            input logic wide);
    logic [31:0] sz;
    sz = wide ? 32'd4 : 32'd2;
    case (code)
      2'd1:    step_addr = a - sz;
      2'd2:    step_addr = a;
      default: step_addr = a + sz;
    endcase
  endfunction
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MAX_UNITS   = 65536,
  parameter bit HAS_FIFO    = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_reg,
  input  logic [31:0] cfg_wdata,
  input  logic        vblank,
  input  logic        hblank,
  input  logic        fifo_req,
  input  logic        unit_done,
  output logic        pending,
  output logic        wide,
  output logic        first,
  output logic [31:0] src_addr,
  output logic [31:0] dst_addr,
  output logic [15:0] ctrl_q,
  output logic        irq
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] MAX_CNT = CW'(MAX_UNITS);

  logic [31:0]   src_reg, dst_reg, wsrc, wdst;
  logic [CW-1:0] cnt_reg, wcnt;
  logic          last, end_blk, en_eff, ctrl_we, trig;
  logic [31:0]   nxt_src, nxt_dst;
  trig_e         tm, tm_new;

  assign wide     = ctrl_q[BIT_W32];
  assign tm       = trig_e'(ctrl_q[13:12]);
  assign tm_new   = trig_e'(cfg_wdata[13:12]);
  assign src_addr = wide ? {wsrc[31:2], 2'b00} : wsrc;
  assign dst_addr = wide ? {wdst[31:2], 2'b00} : wdst;
  assign nxt_src  = step_addr(src_addr, ctrl_q[8:7], wide);
  assign nxt_dst  = step_addr(dst_addr, ctrl_q[6:5], wide);
  assign last     = (wcnt == CW'(1));
  assign end_blk  = unit_done && last;
  // enable as it stands once this cycle's block end is taken into account
  assign en_eff   = ctrl_q[BIT_EN] && !(end_blk && !ctrl_q[BIT_RPT]);
  assign ctrl_we  = cfg_we && (cfg_reg == REG_CTRL);
  assign trig     = en_eff && ((tm == TM_VBL && vblank) || (tm == TM_HBL && hblank) ||
                               (tm == TM_FIFO && HAS_FIFO && fifo_req));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_reg <= '0;
      dst_reg <= '0;
      cnt_reg <= MAX_CNT;
      wsrc    <= '0;
      wdst    <= '0;
      wcnt    <= '0;
      ctrl_q  <= '0;
      pending <= 1'b0;
      first   <= 1'b1;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (cfg_we && cfg_reg == REG_SRC) src_reg <= {cfg_wdata[31:1], 1'b0};
      if (cfg_we && cfg_reg == REG_DST) dst_reg <= {cfg_wdata[31:1], 1'b0};
      if (cfg_we && cfg_reg == REG_CNT)
        cnt_reg <= (cfg_wdata[CNT_W-1:0] == '0) ? MAX_CNT : {1'b0, cfg_wdata[CNT_W-1:0]};

      // progress after a completed unit
      if (unit_done) begin
        wsrc  <= nxt_src;
        first <= 1'b0;
        if (last) begin
          if (ctrl_q[BIT_IRQ]) irq <= 1'b1;
          first <= 1'b1;
          if (ctrl_q[BIT_RPT]) begin
            wcnt    <= cnt_reg;
            wdst    <= (ctrl_q[6:5] == 2'd3) ? dst_reg : nxt_dst;
            pending <= (tm == TM_NOW);
          end else begin
            wcnt    <= '0;
            wdst    <= nxt_dst;
            pending <= 1'b0;
            ctrl_q  <= ctrl_q & END_MASK;
          end
        end else begin
          wcnt <= wcnt - CW'(1);
          wdst <= nxt_dst;
        end
      end

      if (trig) pending <= 1'b1;

      // software control write overrides the engine's update
      if (ctrl_we) begin
        ctrl_q <= cfg_wdata[15:0];
        if (!cfg_wdata[BIT_EN]) begin
          pending <= 1'b0;
        end else if (!en_eff) begin
          wsrc    <= src_reg;
          wdst    <= dst_reg;
          wcnt    <= cnt_reg;
          first   <= 1'b1;
          pending <= (tm_new == TM_NOW);
        end
      end
    end
  end

  // R8: a non-repeating block end with no concurrent control write leaves the channel disabled
  a_r8_end_disables: assert property (@(posedge clk) disable iff (rst)
    (end_blk && !ctrl_q[BIT_RPT] && !ctrl_we) |=> !ctrl_q[BIT_EN]);

  // R10: an interrupt pulse only follows a completed unit
  a_r10_irq_after_unit: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(unit_done));

  // R9: a repeating block keeps its enable unless software clears it
  a_r9_repeat_keeps_en: assert property (@(posedge clk) disable iff (rst)
    (end_blk && ctrl_q[BIT_RPT] && ctrl_q[BIT_EN] && !ctrl_we) |=> ctrl_q[BIT_EN]);
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] sel
);
  always_comb begin
    any = |req;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) sel = IW'(i);
    end
  end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                any,
  input  logic [IW-1:0]       sel,
  input  logic [N-1:0][31:0]  src_a,
  input  logic [N-1:0][31:0]  dst_a,
  input  logic [N-1:0]        wide,
  input  logic [N-1:0]        first,
  output logic                m_valid,
  output logic                m_write,
  output logic                m_wide,
  output logic                m_seq,
  output logic [31:0]         m_addr,
  output logic [31:0]         m_wdata,
  input  logic                m_ready,
  input  logic [31:0]         m_rdata,
  output logic [N-1:0]        done
);
  eng_e          st;
  logic [IW-1:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      cur     <= '0;
      m_valid <= 1'b0;
      m_write <= 1'b0;
      m_wide  <= 1'b0;
      m_seq   <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
    end else begin
      case (st)
        E_IDLE: if (any) begin
          cur     <= sel;
          m_valid <= 1'b1;
          m_write <= 1'b0;
          m_addr  <= src_a[sel];
          m_wide  <= wide[sel];
          m_seq   <= !first[sel];
          st      <= E_RD;
        end
        E_RD: if (m_ready) begin
          m_write <= 1'b1;
          m_addr  <= dst_a[cur];
          m_wdata <= m_wide ? m_rdata : {16'h0000, m_rdata[15:0]};
          st      <= E_WR;
        end
        E_WR: if (m_ready) begin
          m_valid <= 1'b0;
          m_write <= 1'b0;
          st      <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) done[i] = (st == E_WR) && m_ready && (cur == IW'(i));
  end

  // R11: a request is held unchanged until accepted
  a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

  // R11: every unit opens with a read
  a_r11_read_first: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> !m_write);

  // R7: at most one channel finishes a unit per cycle, only on a write handshake
  a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
    (|done) |-> ($onehot0(done) && m_valid && m_write));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_ch,
  input  logic [1:0]  cfg_reg,
  input  logic [31:0] cfg_wdata,
  input  logic [1:0]  ctrl_rd_sel,
  output logic [15:0] ctrl_rd_data,
  input  logic        vblank,
  input  logic        hblank,
  input  logic [1:0]  fifo_req,
  output logic [3:0]  irq,
  output logic        m_valid,
  output logic        m_write,
  output logic        m_wide,
  output logic        m_seq,
  output logic [31:0] m_addr,
  output logic [31:0] m_wdata,
  input  logic        m_ready,
  input  logic [31:0] m_rdata
);
  localparam int IW = 2;

  logic [NCH-1:0]        pend, wide, first, done, irq_v;
  logic [NCH-1:0][31:0]  src_a, dst_a;
  logic [NCH-1:0][15:0]  ctrl_a;
  logic                  any;
  logic [IW-1:0]         sel;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int  UNITS = (i == NCH - 1) ? (1 << CNT_W) : (1 << (CNT_W - 2));
    localparam bit  FIFO  = (i == 1) || (i == 2);
    logic fifo_in;
    if (i == 1) begin : g_f1
      assign fifo_in = fifo_req[0];
    end else if (i == 2) begin : g_f2
      assign fifo_in = fifo_req[1];
    end else begin : g_fn
      assign fifo_in = 1'b0;
    end

    dma4_chan #(.CNT_W(CNT_W), .MAX_UNITS(UNITS), .HAS_FIFO(FIFO)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we && (cfg_ch == IW'(i))),
      .cfg_reg   (cfg_reg),
      .cfg_wdata (cfg_wdata),
      .vblank    (vblank),
      .hblank    (hblank),
      .fifo_req  (fifo_in),
      .unit_done (done[i]),
      .pending   (pend[i]),
      .wide      (wide[i]),
      .first     (first[i]),
      .src_addr  (src_a[i]),
      .dst_addr  (dst_a[i]),
      .ctrl_q    (ctrl_a[i]),
      .irq       (irq_v[i])
    );
  end

  dma4_arb #(.N(NCH), .IW(IW)) u_arb (
    .req (pend),
    .any (any),
    .sel (sel)
  );

  dma4_engine #(.N(NCH), .IW(IW)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .any     (any),
    .sel     (sel),
    .src_a   (src_a),
    .dst_a   (dst_a),
    .wide    (wide),
    .first   (first),
    .m_valid (m_valid),
    .m_write (m_write),
    .m_wide  (m_wide),
    .m_seq   (m_seq),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_ready (m_ready),
    .m_rdata (m_rdata),
    .done    (done)
  );

  assign ctrl_rd_data = ctrl_a[ctrl_rd_sel];
  assign irq          = irq_v;
endmodule

// File: tb/dma4_ctrl_test.sv
module dma4_ctrl_test;
  localparam int CNT_W = 8;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0, cfg_reg = '0, ctrl_rd_sel = '0, fifo_req = '0;
  logic [31:0] cfg_wdata = '0, m_addr, m_wdata, m_rdata;
  logic [15:0] ctrl_rd_data;
  logic        vblank = 1'b0, hblank = 1'b0, m_ready = 1'b1;
  logic [3:0]  irq;
  logic        m_valid, m_write, m_wide, m_seq;

  dma4_ctrl #(.NCH(4), .CNT_W(CNT_W)) uut (.*);

  always #5 clk = ~clk;

  logic [15:0] mem [1024];
  logic [15:0] exp_m [1024];
  logic [31:0] wr_log [2048];
  logic [31:0] rd_log [2048];
  logic        seq_log [2048];
  int wr_cnt = 0, rd_cnt = 0, checks = 0, errors = 0;
  int irq_cnt [4] = '{0, 0, 0, 0};
  bit finished = 1'b0;
  logic [9:0] hidx;

  assign hidx    = m_addr[10:1];
  assign m_rdata = m_wide ? {mem[hidx + 10'd1], mem[hidx]} : {16'h0000, mem[hidx]};

  initial for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 37 + 5);

  // observer: sampled on the falling edge, inputs are driven 1 ns after it
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 4; c++) irq_cnt[c] += int'(irq[c]);
      if (m_valid && m_ready) begin
        if (m_write) begin
          wr_log[wr_cnt[10:0]] = m_addr;
          mem[hidx] = m_wdata[15:0];
          if (m_wide) mem[hidx + 10'd1] = m_wdata[31:16];
          wr_cnt++;
        end else begin
          rd_log[rd_cnt[10:0]] = m_addr;
          seq_log[rd_cnt[10:0]] = m_seq;
          rd_cnt++;
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] r, input logic [31:0] d);
    tick();
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_reg = r; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic wait_off(input int ch);
    int n = 0;
    ctrl_rd_sel = 2'(ch);
    tick();
    while (ctrl_rd_data[15] && n < 5000) begin tick(); n++; end
    check(n < 5000, "R8 block never ended", 32'(ctrl_rd_data), 32'h0);
    repeat (3) tick();
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic pulse(input int which);
    tick();
    if (which == 0) vblank = 1'b1;
    else if (which == 1) hblank = 1'b1;
    else fifo_req = 2'(which - 1);
    tick();
    vblank = 1'b0; hblank = 1'b0; fifo_req = 2'b00;
  endtask

  function automatic logic [15:0] mk(bit en, bit ie, logic [1:0] tm, bit w, bit rpt,
                                     logic [1:0] sc, logic [1:0] dc);
    return {en, ie, tm, 1'b0, w, rpt, sc, dc, 5'b00000};
  endfunction

  function automatic int stepb(int a, logic [1:0] code, bit w);
    int sz = w ? 4 : 2;
    if (code == 2'd1) return a - sz;
    if (code == 2'd2) return a;
    return a + sz;
  endfunction

  typedef struct packed {
    logic [11:0] src; logic [11:0] dst; logic [7:0] cnt;
    logic [1:0] sc; logic [1:0] dc; logic w;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{12'h010, 12'h400, 8'd4, 2'd0, 2'd0, 1'b0},
    '{12'h020, 12'h440, 8'd3, 2'd0, 2'd0, 1'b1},
    '{12'h03E, 12'h480, 8'd4, 2'd1, 2'd0, 1'b0},
    '{12'h050, 12'h4C0, 8'd3, 2'd2, 2'd0, 1'b1},
    '{12'h060, 12'h50E, 8'd4, 2'd0, 2'd1, 1'b0},
    '{12'h070, 12'h540, 8'd3, 2'd0, 2'd2, 1'b1},
    '{12'h081, 12'h581, 8'd2, 2'd3, 2'd3, 1'b0},
    '{12'h096, 12'h5C6, 8'd2, 2'd0, 2'd0, 1'b1}
  };

  initial begin
    int w0, r0, i0, mism, s, d;
    logic [15:0] cw;
    for (int i = 0; i < 1024; i++) exp_m[i] = 16'(i * 37 + 5);
    repeat (5) @(posedge clk);
    tick();
    rst = 1'b0;
    tick();

    // reset state
    check(!m_valid, "R11 reset m_valid", 32'(m_valid), 32'h0);
    check(irq == 4'h0, "R10 reset irq", 32'(irq), 32'h0);
    check(ctrl_rd_data == 16'h0, "R8 reset ctrl", 32'(ctrl_rd_data), 32'h0);

    // table of immediate transfers on channel 1 (R1 R3 R8 R11)
    for (int v = 0; v < 8; v++) begin
      r0 = rd_cnt;
      cw = mk(1, 0, 2'd0, VEC[v].w, 0, VEC[v].sc, VEC[v].dc);
      wr(1, 2'd0, 32'(VEC[v].src));
      wr(1, 2'd1, 32'(VEC[v].dst));
      wr(1, 2'd2, 32'(VEC[v].cnt));
      wr(1, 2'd3, 32'(cw));
      wait_off(1);
      s = int'(VEC[v].src) & ~1; d = int'(VEC[v].dst) & ~1;
      if (VEC[v].w) begin s = s & ~3; d = d & ~3; end
      check(rd_log[r0[10:0]] == 32'(s), "R1 first read address", rd_log[r0[10:0]], 32'(s));
      for (int k = 0; k < int'(VEC[v].cnt); k++) begin
        exp_m[d >> 1] = exp_m[s >> 1];
        if (VEC[v].w) exp_m[(d >> 1) + 1] = exp_m[(s >> 1) + 1];
        s = stepb(s, VEC[v].sc, VEC[v].w);
        d = stepb(d, VEC[v].dc, VEC[v].w);
      end
      mism = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] != exp_m[i]) mism++;
      check(mism == 0, "R3 memory image mismatches", 32'(mism), 32'h0);
      check(ctrl_rd_data == (cw & 16'h7FE0), "R8 control after end", 32'(ctrl_rd_data),
            32'(cw & 16'h7FE0));
      check(seq_log[r0[10:0]] == 1'b0 && seq_log[r0[10:0] + 11'd1] == 1'b1, "R11 seq flags",
            {30'h0, seq_log[r0[10:0]], seq_log[r0[10:0] + 11'd1]}, 32'h1);
    end

    // R2: count 0 maxima, scaled by CNT_W
    w0 = wr_cnt;
    wr(0, 2'd0, 32'h000); wr(0, 2'd1, 32'h600); wr(0, 2'd2, 32'h0);
    wr(0, 2'd3, 32'(mk(1, 0, 2'd0, 0, 0, 2'd2, 2'd2)));
    wait_off(0);
    check(wr_cnt - w0 == 64, "R2 channel 0 zero count", 32'(wr_cnt - w0), 32'd64);
    w0 = wr_cnt;
    wr(3, 2'd0, 32'h000); wr(3, 2'd1, 32'h600); wr(3, 2'd2, 32'h0);
    wr(3, 2'd3, 32'(mk(1, 0, 2'd0, 0, 0, 2'd2, 2'd2)));
    wait_off(3);
    check(wr_cnt - w0 == 256, "R2 channel 3 zero count", 32'(wr_cnt - w0), 32'd256);

    // R6: channel 0 ignores the FIFO trigger code
    w0 = wr_cnt;
    wr(0, 2'd2, 32'd2);
    wr(0, 2'd3, 32'(mk(1, 0, 2'd3, 0, 0, 2'd0, 2'd0)));
    pulse(0); pulse(1); pulse(2); pulse(3);
    idle(20);
    ctrl_rd_sel = 2'd0; tick();
    check(wr_cnt == w0 && ctrl_rd_data[15], "R6 channel 0 special discarded", 32'(wr_cnt - w0), 32'h0);
    wr(0, 2'd3, 32'h0);

    // R6: channel 1 FIFO trigger
    w0 = wr_cnt;
    wr(1, 2'd0, 32'h100); wr(1, 2'd1, 32'h700); wr(1, 2'd2, 32'd2);
    wr(1, 2'd3, 32'(mk(1, 0, 2'd3, 0, 0, 2'd0, 2'd0)));
    pulse(0); pulse(1); pulse(3);
    idle(20);
    check(wr_cnt == w0, "R6 channel 1 waits for its FIFO", 32'(wr_cnt - w0), 32'h0);
    pulse(2);
    wait_off(1);
    check(wr_cnt - w0 == 2, "R6 channel 1 FIFO block", 32'(wr_cnt - w0), 32'd2);

    // R6 and R5: channel 2 on vblank, source rewritten while enabled
    w0 = wr_cnt; r0 = rd_cnt;
    wr(2, 2'd0, 32'h120); wr(2, 2'd1, 32'h710); wr(2, 2'd2, 32'd1);
    wr(2, 2'd3, 32'(mk(1, 0, 2'd1, 0, 0, 2'd0, 2'd0)));
    wr(2, 2'd0, 32'h180);
    pulse(1);
    idle(20);
    check(wr_cnt == w0, "R6 vblank channel ignores hblank", 32'(wr_cnt - w0), 32'h0);
    pulse(0);
    wait_off(2);
    check(rd_log[r0[10:0]] == 32'h120, "R5 source latched at enable", rd_log[r0[10:0]], 32'h120);

    // R4 R9 R10: repeat on hblank with destination reload and interrupt
    w0 = wr_cnt; r0 = rd_cnt; i0 = irq_cnt[2];
    wr(2, 2'd0, 32'h200); wr(2, 2'd1, 32'h720); wr(2, 2'd2, 32'd2);
    wr(2, 2'd3, 32'(mk(1, 1, 2'd2, 0, 1, 2'd0, 2'd3)));
    idle(20);
    check(wr_cnt == w0, "R9 repeat channel waits for trigger", 32'(wr_cnt - w0), 32'h0);
    pulse(1); idle(20);
    ctrl_rd_sel = 2'd2; tick();
    check(wr_cnt - w0 == 2 && ctrl_rd_data[15], "R9 enable kept after block",
          {16'(wr_cnt - w0), ctrl_rd_data}, {16'd2, 16'h8000});
    check(irq_cnt[2] - i0 == 1, "R10 one irq cycle per block", 32'(irq_cnt[2] - i0), 32'd1);
    pulse(1); idle(20);
    check(wr_log[w0[10:0] + 11'd2] == 32'h720, "R4 destination reloaded",
          wr_log[w0[10:0] + 11'd2], 32'h720);
    check(rd_log[r0[10:0] + 11'd2] == 32'h204, "R4 source carries on",
          rd_log[r0[10:0] + 11'd2], 32'h204);
    check(irq_cnt[2] - i0 == 2, "R10 second block irq", 32'(irq_cnt[2] - i0), 32'd2);
    wr(2, 2'd3, 32'h0);

    // R4: destination code 0 in repeat mode carries on, no irq without bit 14
    w0 = wr_cnt; i0 = irq_cnt[2];
    wr(2, 2'd1, 32'h730);
    wr(2, 2'd3, 32'(mk(1, 0, 2'd2, 0, 1, 2'd0, 2'd0)));
    pulse(1); idle(20); pulse(1); idle(20);
    check(wr_log[w0[10:0] + 11'd2] == 32'h734, "R4 code 0 destination carries on",
          wr_log[w0[10:0] + 11'd2], 32'h734);
    check(irq_cnt[2] == i0, "R10 no irq when disabled", 32'(irq_cnt[2] - i0), 32'h0);
    wr(2, 2'd3, 32'h0);

    // R7: channel 0 overtakes channel 2 at a unit boundary
    w0 = wr_cnt;
    tick(); m_ready = 1'b0;
    wr(2, 2'd0, 32'h300); wr(2, 2'd1, 32'h740); wr(2, 2'd2, 32'd3);
    wr(0, 2'd0, 32'h320); wr(0, 2'd1, 32'h760); wr(0, 2'd2, 32'd2);
    wr(2, 2'd3, 32'(mk(1, 0, 2'd0, 0, 0, 2'd0, 2'd0)));
    wr(0, 2'd3, 32'(mk(1, 0, 2'd0, 0, 0, 2'd0, 2'd0)));
    tick(); m_ready = 1'b1;
    wait_off(2);
    check(wr_log[w0[10:0]] == 32'h740, "R7 started unit finishes", wr_log[w0[10:0]], 32'h740);
    check(wr_log[w0[10:0] + 11'd1] == 32'h760 && wr_log[w0[10:0] + 11'd2] == 32'h762,
          "R7 lower channel takes over", wr_log[w0[10:0] + 11'd1], 32'h760);
    check(wr_log[w0[10:0] + 11'd3] == 32'h742, "R7 higher channel resumes",
          wr_log[w0[10:0] + 11'd3], 32'h742);

    // R12: control write with enable on the final write handshake
    w0 = wr_cnt; r0 = rd_cnt;
    wr(1, 2'd0, 32'h3A0); wr(1, 2'd1, 32'h780); wr(1, 2'd2, 32'd1);
    cw = mk(1, 0, 2'd0, 0, 0, 2'd0, 2'd0);
    wr(1, 2'd3, 32'(cw));
    begin
      int n = 0;
      while (!(m_valid && m_write) && n < 50) begin tick(); n++; end
    end
    cfg_we = 1'b1; cfg_ch = 2'd1; cfg_reg = 2'd3; cfg_wdata = 32'(cw);
    tick();
    cfg_we = 1'b0;
    wait_off(1);
    check(wr_cnt - w0 == 2, "R12 collision starts a fresh block", 32'(wr_cnt - w0), 32'd2);
    check(rd_log[r0[10:0] + 11'd1] == 32'h3A0, "R12 relatched source",
          rd_log[r0[10:0] + 11'd1], 32'h3A0);
    check(ctrl_rd_data == (cw & 16'h7FE0), "R12 control after second block",
          32'(ctrl_rd_data), 32'(cw & 16'h7FE0));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule